// File: doc/BRIEF.md
# I2C Expander Polling Sequencer

This block walks one I2C byte master through a fixed window of eight port-expander addresses each time a periodic trigger arrives, normally once per millisecond. For every address slot it moves exactly one byte. A direction mask picks the operation for each slot: write the slot's output byte, or read a byte into the slot's input register. Each failed transaction increments that slot's error counter. These counters show which expanders are missing or misbehaving.

After a fixed settling time, counted by a prescaled timer, the block looks at every error counter once. Any slot whose count is above a limit is retired for good, and later sweeps step over it, so they finish sooner. While the block is idle it can also run a single one-shot transaction to any 7-bit address. The result comes back on a separate port with its own completion pulse, and the one-shot leaves the sweep state untouched.

Top module: `exp_poll_seq`

## Requirements
- R1: A pulse on `trig_i` while idle starts a sweep. `busy_o` is high from the cycle after the trigger until the cycle in which `done_o` pulses. A trigger during a sweep has no effect. A trigger together with `shot_req_i` in the same idle cycle starts the sweep, and the one-shot is dropped.
- R2: A sweep issues one transaction per enabled slot, in ascending slot order. Slot i uses address `BASE_ADDR`+i, giving 0x20 to 0x27 by default.
- R3: Bit i of `dir_wr_i` set to 1 makes slot i a write of `wdata_i[8i+7:8i]` with `m_rd_o`=0. Set to 0, it makes slot i a read with `m_rd_o`=1.
- R4: A transaction that ends with `m_err_i`=1 adds one to that slot's counter in `errcnt_o[ERR_W*i +: ERR_W]`. The counter stops at all-ones and does not wrap.
- R5: A read that ends without error stores `m_rdata_i` into `rdata_o[8i+7:8i]`. A failed read, or any write, leaves that byte unchanged.
- R6: `done_o` is a one-cycle pulse that ends each sweep, and the block is idle again in the same cycle. If no slot is enabled, `done_o` pulses the cycle after the trigger and no transaction is issued.
- R7: Exactly `PRESCALE`*`EVAL_TICKS` cycles after reset, every slot whose counter is greater than `ERR_LIMIT` gets its bit set in `disabled_o`. Before that point `disabled_o` is zero, and once a bit is set it stays set.
- R8: Sweeps never address a slot whose `disabled_o` bit is set.
- R9: A `shot_req_i` pulse while idle runs one transaction to `shot_addr_i`, with direction `shot_rd_i` and data `shot_wdata_i`. When it ends, `shot_done_o` pulses, `shot_err_o` takes `m_err_i`, and a successful read stores the byte in `shot_rdata_o`. The one-shot changes no error counter and no slot byte, and it does not pulse `done_o`. A request while a sweep is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Sweep start pulse |
| dir_wr_i | input | NSLOT | Per-slot direction, 1 = write |
| wdata_i | input | 8*NSLOT | Per-slot write bytes |
| rdata_o | output | 8*NSLOT | Per-slot read bytes |
| errcnt_o | output | ERR_W*NSLOT | Per-slot saturating error counters |
| disabled_o | output | NSLOT | Retired slots |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | Sweep finished pulse |
| shot_req_i | input | 1 | One-shot request pulse |
| shot_addr_i | input | 7 | One-shot address |
| shot_rd_i | input | 1 | One-shot direction, 1 = read |
| shot_wdata_i | input | 8 | One-shot write byte |
| shot_done_o | output | 1 | One-shot finished pulse |
| shot_rdata_o | output | 8 | One-shot read byte |
| shot_err_o | output | 1 | One-shot error flag |
| m_req_o | output | 1 | Transaction request, held until acknowledged |
| m_addr_o | output | 7 | Transaction address |
| m_rd_o | output | 1 | Transaction is a read |
| m_wdata_o | output | 8 | Write byte |
| m_ack_i | input | 1 | Transaction finished, one-cycle pulse |
| m_err_i | input | 1 | NACK or other failure, valid with m_ack_i |
| m_rdata_i | input | 8 | Read byte, valid with m_ack_i |

## Verification
The assertions check several rules on every cycle. Sweep addresses rise within a sweep and stay inside the window. No retired slot is ever issued. Counters never fall and never leave all-ones. Retirement bits are sticky. The two completion pulses last one cycle and never coincide. The exact order of visited slots, the write bytes, the counter and read-byte values, and which slots end up retired can only be shown by the bench's scenarios. These scenarios pair a modelled expander bus that fails some addresses always and others at random with a model that predicts every counter. Ignored triggers and dropped one-shots are also shown at the ports, by the transaction count and the absence of pulses.

// File: rtl/exp_poll_seq.sv
module exp_poll_seq #(
  parameter int          NSLOT      = 8,
  parameter logic [6:0]  BASE_ADDR  = 7'h20,
  parameter int          ERR_W      = 16,
  parameter int          ERR_LIMIT  = 9990,
  parameter int          PRESCALE   = 50000,
  parameter int          EVAL_TICKS = 10000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   trig_i,
  input  logic [NSLOT-1:0]       dir_wr_i,
  input  logic [8*NSLOT-1:0]     wdata_i,
  output logic [8*NSLOT-1:0]     rdata_o,
  output logic [ERR_W*NSLOT-1:0] errcnt_o,
  output logic [NSLOT-1:0]       disabled_o,
  output logic                   busy_o,
  output logic                   done_o,
  input  logic                   shot_req_i,
  input  logic [6:0]             shot_addr_i,
  input  logic                   shot_rd_i,
  input  logic [7:0]             shot_wdata_i,
  output logic                   shot_done_o,
  output logic [7:0]             shot_rdata_o,
  output logic                   shot_err_o,
  output logic                   m_req_o,
  output logic [6:0]             m_addr_o,
  output logic                   m_rd_o,
  output logic [7:0]             m_wdata_o,
  input  logic                   m_ack_i,
  input  logic                   m_err_i,
  input  logic [7:0]             m_rdata_i
);

  localparam int SW = $clog2(NSLOT);
  localparam int PW = $clog2(PRESCALE);
  localparam int TW = $clog2(EVAL_TICKS);

  typedef enum logic [1:0] {S_IDLE, S_SWEEP, S_SHOT} state_t;

  state_t       st;
  logic [SW-1:0] idx;
  logic [6:0]   shot_addr_q;
  logic         shot_rd_q;
  logic [7:0]   shot_wdata_q;
  logic [SW:0]  first_en, next_en;
  logic [PW-1:0] pre_cnt;
  logic [TW-1:0] tick_cnt;
  logic         eval_done, eval_now;

  function automatic logic [SW:0] find_en(input logic [NSLOT-1:0] dis, input int from);
    logic [SW:0] r;
    r = '0;
    for (int j = NSLOT - 1; j >= 0; j--)
      if (j >= from && !dis[j]) r = {1'b1, SW'(j)};
    return r;
  endfunction

  assign first_en = find_en(disabled_o, 0);
  assign next_en  = find_en(disabled_o, int'(idx) + 1);

  assign m_req_o   = (st != S_IDLE);
  assign m_addr_o  = (st == S_SHOT) ? shot_addr_q  : BASE_ADDR + 7'(idx);
  assign m_rd_o    = (st == S_SHOT) ? shot_rd_q    : !dir_wr_i[idx];
  assign m_wdata_o = (st == S_SHOT) ? shot_wdata_q : wdata_i[idx*8 +: 8];
  assign busy_o    = (st == S_SWEEP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      idx          <= '0;
      done_o       <= 1'b0;
      shot_done_o  <= 1'b0;
      shot_addr_q  <= '0;
      shot_rd_q    <= 1'b0;
      shot_wdata_q <= '0;
      shot_rdata_o <= '0;
      shot_err_o   <= 1'b0;
    end else begin
      done_o      <= 1'b0;
      shot_done_o <= 1'b0;
      case (st)
        S_IDLE: begin
          if (trig_i) begin
            if (first_en[SW]) begin
              st  <= S_SWEEP;
              idx <= first_en[SW-1:0];
            end else begin
              done_o <= 1'b1;
            end
          end else if (shot_req_i) begin
            st           <= S_SHOT;
            shot_addr_q  <= shot_addr_i;
            shot_rd_q    <= shot_rd_i;
            shot_wdata_q <= shot_wdata_i;
          end
        end
        S_SWEEP: begin
          if (m_ack_i) begin
            if (next_en[SW]) begin
              idx <= next_en[SW-1:0];
            end else begin
              st     <= S_IDLE;
              done_o <= 1'b1;
            end
          end
        end
        S_SHOT: begin
          if (m_ack_i) begin
            st          <= S_IDLE;
            shot_done_o <= 1'b1;
            shot_err_o  <= m_err_i;
            if (shot_rd_q && !m_err_i) shot_rdata_o <= m_rdata_i;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign eval_now = !eval_done && (pre_cnt == PW'(PRESCALE - 1)) && (tick_cnt == TW'(EVAL_TICKS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_cnt   <= '0;
      tick_cnt  <= '0;
      eval_done <= 1'b0;
    end else if (!eval_done) begin
      if (pre_cnt == PW'(PRESCALE - 1)) begin
        pre_cnt <= '0;
        if (tick_cnt == TW'(EVAL_TICKS - 1)) eval_done <= 1'b1;
        else                                 tick_cnt  <= tick_cnt + 1'b1;
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic [ERR_W-1:0] cnt;
    logic [7:0]       rbyte;
    logic             hit;

    assign hit = (st == S_SWEEP) && m_ack_i && (idx == SW'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt           <= '0;
        rbyte         <= '0;
        disabled_o[g] <= 1'b0;
      end else begin
        if (hit && m_err_i && cnt != '1) cnt <= cnt + 1'b1;
        if (hit && !m_err_i && !dir_wr_i[g]) rbyte <= m_rdata_i;
        if (eval_now && int'(cnt) > ERR_LIMIT) disabled_o[g] <= 1'b1;
      end
    end

    assign errcnt_o[g*ERR_W +: ERR_W] = cnt;
    assign rdata_o[g*8 +: 8]          = rbyte;
  end

endmodule

// File: rtl/exp_poll_seq_chk.sv
module exp_poll_seq_chk #(
  parameter int         NSLOT     = 8,
  parameter logic [6:0] BASE_ADDR = 7'h20,
  parameter int         ERR_W     = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   busy_o,
  input logic                   done_o,
  input logic                   shot_done_o,
  input logic                   m_req_o,
  input logic [6:0]             m_addr_o,
  input logic                   m_ack_i,
  input logic [NSLOT-1:0]       disabled_o,
  input logic [ERR_W*NSLOT-1:0] errcnt_o
);

  localparam int SW = $clog2(NSLOT);

  logic [6:0]       offs;
  logic [NSLOT-1:0] slot_bit;
  assign offs     = m_addr_o - BASE_ADDR;
  assign slot_bit = NSLOT'(1) << offs[SW-1:0];

  AST_SWEEP_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && m_req_o) |-> (m_addr_o >= BASE_ADDR && int'(offs) < NSLOT)); // R2

  AST_SWEEP_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && m_ack_i) |=> (!busy_o || m_addr_o > $past(m_addr_o))); // R2

  AST_NO_RETIRED_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && (!$past(busy_o) || $past(m_ack_i))) |-> (($past(disabled_o) & slot_bit) == '0)); // R8

  AST_RETIRE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(disabled_o) & ~disabled_o) == '0)); // R7

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R6

  AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o); // R1

  AST_SHOT_APART: assert property (@(posedge clk) disable iff (!rst_n)
    shot_done_o |-> (!done_o && !busy_o)); // R9

  for (genvar g = 0; g < NSLOT; g++) begin : g_cnt
    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      errcnt_o[g*ERR_W +: ERR_W] >= $past(errcnt_o[g*ERR_W +: ERR_W])); // R4
  end

endmodule

bind exp_poll_seq exp_poll_seq_chk #(.NSLOT(NSLOT), .BASE_ADDR(BASE_ADDR), .ERR_W(ERR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .done_o(done_o), .shot_done_o(shot_done_o),
  .m_req_o(m_req_o), .m_addr_o(m_addr_o), .m_ack_i(m_ack_i),
  .disabled_o(disabled_o), .errcnt_o(errcnt_o)
);

// File: tb/exp_poll_seq_tb_top.sv
`timescale 1ns/1ps
module exp_poll_seq_tb_top;
  localparam int NS = 8;
  localparam int EW = 4;
  localparam int LIM = 5;
  localparam int PRE = 40;
  localparam int TICKS = 50;

  logic clk = 0, rst_n = 0;
  logic trig = 0, shot_req = 0, shot_rd = 0;
  logic [6:0] shot_addr = 0;
  logic [7:0] shot_wdata = 0;
  logic [NS-1:0] dir = 0;
  logic [8*NS-1:0] wdata = 0;
  logic [8*NS-1:0] rdata;
  logic [EW*NS-1:0] errcnt;
  logic [NS-1:0] dis;
  logic busy, done, shot_done, shot_err, m_req, m_rd;
  logic [7:0] shot_rdata, m_wdata;
  logic [6:0] m_addr;
  logic ack = 0, merr = 0;
  logic [7:0] mrdata = 0;

  always #10 clk = ~clk;

  exp_poll_seq #(.NSLOT(NS), .ERR_W(EW), .ERR_LIMIT(LIM), .PRESCALE(PRE), .EVAL_TICKS(TICKS)) dut_i (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .dir_wr_i(dir), .wdata_i(wdata), .rdata_o(rdata),
    .errcnt_o(errcnt), .disabled_o(dis), .busy_o(busy), .done_o(done),
    .shot_req_i(shot_req), .shot_addr_i(shot_addr), .shot_rd_i(shot_rd), .shot_wdata_i(shot_wdata),
    .shot_done_o(shot_done), .shot_rdata_o(shot_rdata), .shot_err_o(shot_err),
    .m_req_o(m_req), .m_addr_o(m_addr), .m_rd_o(m_rd), .m_wdata_o(m_wdata),
    .m_ack_i(ack), .m_err_i(merr), .m_rdata_i(mrdata));

  int checks = 0, fails = 0, cyc = 0;
  logic [NS-1:0] present = 8'b0110_1011;

  logic [6:0] lg_addr [1024];
  logic       lg_rd   [1024];
  logic [7:0] lg_wd   [1024];
  logic       lg_err  [1024];
  logic [7:0] lg_rdat [1024];
  int nlog = 0;

  int exp_cnt [NS];
  logic [7:0] exp_rd [NS];
  logic [NS-1:0] exp_dis = 0;
  logic [7:0] exp_shot_rd = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  int pend = 0, lat = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      ack = 0; pend = 0;
    end else if (ack) begin
      ack = 0;
    end else if (m_req) begin
      if (!pend) begin pend = 1; lat = $urandom_range(0, 2); end
      if (lat == 0) begin
        pend = 0;
        ack = 1;
        mrdata = 8'($urandom);
        if (m_addr >= 7'h20 && m_addr <= 7'h27 && !present[m_addr - 7'h20]) merr = 1;
        else merr = ($urandom % 16) == 0;
        lg_addr[nlog] = m_addr; lg_rd[nlog] = m_rd; lg_wd[nlog] = m_wdata;
        lg_err[nlog] = merr; lg_rdat[nlog] = mrdata;
        nlog++;
      end else lat--;
    end
  end

  function automatic logic [EW*NS-1:0] pack_cnt();
    logic [EW*NS-1:0] r;
    for (int i = 0; i < NS; i++) r[i*EW +: EW] = EW'(exp_cnt[i]);
    return r;
  endfunction

  function automatic logic [8*NS-1:0] pack_rd();
    logic [8*NS-1:0] r;
    for (int i = 0; i < NS; i++) r[i*8 +: 8] = exp_rd[i];
    return r;
  endfunction

  task automatic run_sweep(input bit noise, input bit with_shot);
    int start, k, n_en, t;
    bit shot_seen;
    @(negedge clk);
    dir = NS'($urandom);
    wdata = {$urandom, $urandom};
    trig = 1;
    shot_req = with_shot;
    shot_addr = 7'h44; shot_rd = 1;
    start = nlog;
    n_en = 0;
    for (int i = 0; i < NS; i++) if (!exp_dis[i]) n_en++;
    @(negedge clk);
    trig = 0; shot_req = 0;
    shot_seen = 0;
    if (n_en > 0) chk(busy == 1, "R1", "busy after trigger", busy, 1);
    else chk(done == 1, "R6", "empty sweep done", done, 1);
    t = 0;
    while (!done && t < 500) begin
      @(negedge clk);
      trig = 0; shot_req = 0;
      if (shot_done) shot_seen = 1;
      if (noise && t == 2) trig = 1;
      if (noise && t == 4) shot_req = 1;
      t++;
    end
    chk(done == 1, "R6", "sweep completes", done, 1);
    @(negedge clk);
    trig = 0; shot_req = 0;
    if (shot_done) shot_seen = 1;
    chk(done == 0 && busy == 0, "R6", "done one pulse, idle", {done, busy}, 0);
    chk(nlog - start == n_en, "R2", "transactions per sweep", nlog - start, n_en);
    k = start;
    for (int i = 0; i < NS; i++) begin
      if (exp_dis[i]) continue;
      if (k < nlog) begin
        chk(lg_addr[k] == 7'h20 + 7'(i), "R8", "sweep address order", lg_addr[k], 7'h20 + 7'(i));
        chk(lg_rd[k] == !dir[i], "R3", "direction", lg_rd[k], !dir[i]);
        if (dir[i]) chk(lg_wd[k] == wdata[i*8 +: 8], "R3", "write byte", lg_wd[k], wdata[i*8 +: 8]);
        if (lg_err[k]) exp_cnt[i] = (exp_cnt[i] == (1 << EW) - 1) ? exp_cnt[i] : exp_cnt[i] + 1;
        else if (lg_rd[k]) exp_rd[i] = lg_rdat[k];
      end
      k++;
    end
    repeat (3) begin
      @(negedge clk);
      if (shot_done) shot_seen = 1;
    end
    chk(m_req == 0 && nlog - start == n_en, "R1", "late trigger ignored", nlog - start, n_en);
    chk(!shot_seen, "R9", "one-shot dropped during sweep", shot_seen, 0);
    chk(errcnt == pack_cnt(), "R4", "error counters", errcnt, pack_cnt());
    chk(rdata == pack_rd(), "R5", "read bytes", rdata, pack_rd());
  endtask

  task automatic run_shot(input logic [6:0] a, input bit rd, input logic [7:0] wd);
    int start, t;
    bit done_seen;
    logic [EW*NS-1:0] c0;
    logic [8*NS-1:0] r0;
    c0 = errcnt; r0 = rdata;
    @(negedge clk);
    shot_req = 1; shot_addr = a; shot_rd = rd; shot_wdata = wd;
    start = nlog;
    @(negedge clk);
    shot_req = 0;
    t = 0; done_seen = 0;
    while (!shot_done && t < 100) begin
      if (done || busy) done_seen = 1;
      @(negedge clk);
      t++;
    end
    chk(shot_done == 1, "R9", "one-shot done", shot_done, 1);
    chk(nlog - start == 1, "R9", "one transaction", nlog - start, 1);
    if (nlog - start == 1) begin
      chk(lg_addr[start] == a && lg_rd[start] == rd, "R9", "one-shot addr/dir", {lg_addr[start], lg_rd[start]}, {a, rd});
      if (!rd) chk(lg_wd[start] == wd, "R9", "one-shot write byte", lg_wd[start], wd);
      if (rd && !lg_err[start]) exp_shot_rd = lg_rdat[start];
      chk(shot_err == lg_err[start], "R9", "one-shot error", shot_err, lg_err[start]);
    end
    chk(shot_rdata == exp_shot_rd, "R9", "one-shot read byte", shot_rdata, exp_shot_rd);
    @(negedge clk);
    chk(shot_done == 0 && !done_seen && done == 0, "R9", "no sweep activity", {shot_done, done_seen, done}, 0);
    chk(errcnt == c0 && rdata == r0, "R9", "slot state untouched", errcnt, c0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < NS; i++) begin exp_cnt[i] = 0; exp_rd[i] = 0; end
    repeat (4) @(negedge clk);
    chk(busy == 0 && done == 0 && m_req == 0, "R1", "reset idle", {busy, done, m_req}, 0);
    chk(errcnt == 0 && rdata == 0 && dis == 0, "R7", "reset state", {dis, errcnt}, 0);
    rst_n = 1;
    for (int s = 0; s < 20; s++) begin
      run_sweep(s % 3 == 1, s == 5);
      if (s == 7) run_shot(7'h51, 1, 8'h00);
      if (s == 9) run_shot(7'h23, 0, 8'hA5);
      if (s == 12) run_shot(7'h22, 1, 8'h00);
    end
    chk(errcnt[2*EW +: EW] == '1, "R4", "absent slot counter saturated", errcnt[2*EW +: EW], 4'hF);
    chk(dis == 0, "R7", "no retirement before evaluation", dis, 0);
    while (cyc < 2100) @(negedge clk);
    for (int i = 0; i < NS; i++) exp_dis[i] = exp_cnt[i] > LIM;
    chk(dis == exp_dis, "R7", "retired set after evaluation", dis, exp_dis);
    chk(exp_dis[2] && exp_dis[4] && exp_dis[7], "R7", "absent slots retired", exp_dis, 8'h94);
    for (int s = 0; s < 6; s++) run_sweep(s == 2, 0);
    run_shot(7'h27, 1, 8'h00);
    chk(dis == exp_dis, "R7", "retired set sticky", dis, exp_dis);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule